// File: doc/BRIEF.md
# Multi-Cycle 32-bit Processor Core

This core runs a small load/store instruction subset: word load and store, five register-to-register operations, branch-if-equal and an unconditional jump. It spends between two and five clock cycles on each instruction. One memory port serves both instruction fetch and data access. One ALU does all arithmetic: the operations themselves, the PC increment and the branch target. Values that one step produces for a later step are held in internal staging registers: the instruction word, the loaded data, the two source operands and the ALU result.

A step-sequenced controller walks each instruction through its steps. These are fetch, decode, execute or address generation, memory access or register write, and load write-back. The controller returns to fetch after the last step. In that last cycle it raises a one-cycle retire pulse. The core also shows every register-file write request on its ports, which lets the surrounding logic follow the architectural result of each instruction. The memory is outside the core. It answers a read in the same cycle as the request and takes a write on the clock edge that ends the cycle in which the write is requested.

Top module: `mc_core`

## Requirements
- R1: While reset is held, the core presents address 0, requests no memory write and no register write, and does not retire. The first fetch after reset reads address 0.
- R2: The first cycle of every instruction reads memory at the current PC and stores the word in the instruction register. The PC then becomes PC+4, unless a later step of the same instruction overwrites it.
- R3: Instruction fields are: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0], immediate [15:0], jump index [25:0]. Opcode 0x00 is register-to-register. Its funct codes are 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR and 0x2A set-if-less-than (signed, result 1 or 0). The result is written to rd.
- R4: A load (opcode 0x23) reads memory at rs + sign-extended immediate and writes the word to rt in its fifth cycle. It retires in that same cycle.
- R5: A store (opcode 0x2B) writes rt to memory at rs + sign-extended immediate in its fourth cycle and writes no register.
- R6: A branch (opcode 0x04) takes three cycles and writes nothing. When rs equals rs' partner rt, the next fetch is at PC+4 + (sign-extended immediate << 2). Otherwise the next fetch is at PC+4.
- R7: A jump (opcode 0x02) takes three cycles and writes nothing. The next fetch is at {upper 4 bits of PC+4, jump index, 2'b00}.
- R8: A register-to-register instruction takes four cycles and writes rd in its fourth cycle.
- R9: Any other opcode retires in its second cycle, writes neither a register nor memory, and is followed by a fetch at PC+4.
- R10: Register 0 always reads as zero, even after a write to it has been requested.
- R11: No cycle has both a memory read and a memory write. The retire pulse never lasts more than one cycle. Data accesses use the address computed in an earlier step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_addr | output | 32 | Byte address for fetch or data access |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write request, taken at the end of the cycle |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data, valid in the same cycle |
| retire | output | 1 | One-cycle pulse in an instruction's final cycle |
| rf_wr_en | output | 1 | Register write request this cycle |
| rf_wr_idx | output | 5 | Register index being written |
| rf_wr_data | output | 32 | Value being written |

## Verification
Some cycles carry two jobs on shared hardware. In fetch, the memory port reads the instruction while the ALU adds 4 to the PC. In decode, the register file reads both operands while the ALU forms the branch target from the PC that fetch has just updated. In the branch step, the comparison result decides whether that stored target replaces the PC. The program exercises these overlaps with branches both taken and not taken, a backward branch that closes a countdown loop, and a jump to itself. The bench runs its own instruction-level model and judges the results at the ports. It checks the address of every fetch, each register and memory write at its expected cycle, and the retire cycle of every instruction. A fault in any of these overlaps therefore shows up as a wrong fetch address, a wrong written value or a shifted retire pulse.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int XLEN   = 32;
  localparam int NREGS  = 32;
  localparam int RIDX_W = $clog2(NREGS);

  localparam logic [5:0] OP_REG  = 6'h00;
  localparam logic [5:0] OP_JMP  = 6'h02;
  localparam logic [5:0] OP_BEQ  = 6'h04;
  localparam logic [5:0] OP_LOAD = 6'h23;
  localparam logic [5:0] OP_STOR = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {AF_AND, AF_OR, AF_ADD, AF_SUB, AF_SLT} alu_fn_e;
  typedef enum logic [1:0] {AM_ADD = 2'b00, AM_SUB = 2'b01, AM_FUNCT = 2'b10} alu_mode_e;
  typedef enum logic [1:0] {SB_REG, SB_FOUR, SB_IMM, SB_IMMX4} srcb_e;
  typedef enum logic [1:0] {PS_ALU, PS_HELD, PS_JUMP} pcsrc_e;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_ADDR, ST_LDRD, ST_LDWB,
    ST_STWR, ST_REXE, ST_RWB, ST_BR, ST_JMP
  } step_e;

  typedef struct packed {
    logic      pc_we;
    logic      pc_we_cond;
    logic      data_addr;
    logic      mem_re;
    logic      mem_we;
    logic      wb_mem;
    logic      ir_we;
    logic      ab_we;
    logic      out_we;
    logic      dst_rd;
    logic      rf_we;
    logic      srca_reg;
    srcb_e     srcb;
    alu_mode_e aluop;
    pcsrc_e    pcsrc;
    logic      retire;
  } ctl_t;

  function automatic logic op_known(input logic [5:0] op);
    return (op == OP_REG) || (op == OP_JMP) || (op == OP_BEQ) ||
           (op == OP_LOAD) || (op == OP_STOR);
  endfunction
endpackage

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  alu_mode_e    mode,
  input  logic [5:0]   funct,
  output logic [W-1:0] result,
  output logic         zero
);
  alu_fn_e fn;

  always_comb begin
    case (mode)
      AM_ADD: fn = AF_ADD;
      AM_SUB: fn = AF_SUB;
      default: begin
        case (funct)
          FN_SUB:  fn = AF_SUB;
          FN_AND:  fn = AF_AND;
          FN_OR:   fn = AF_OR;
          FN_SLT:  fn = AF_SLT;
          default: fn = AF_ADD;
        endcase
      end
    endcase
  end

  always_comb begin
    case (fn)
      AF_AND:  result = op_a & op_b;
      AF_OR:   result = op_a | op_b;
      AF_SUB:  result = op_a - op_b;
      AF_SLT:  result = {{(W-1){1'b0}}, ($signed(op_a) < $signed(op_b))};
      default: result = op_a + op_b;
    endcase
  end

  assign zero = (result == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b
);
  logic [W-1:0] cells [N];

  always_ff @(posedge clk) begin
    if (we && (wa != '0)) cells[wa] <= wd;
  end

  assign rd_a = (ra == '0) ? '0 : cells[ra];
  assign rd_b = (rb == '0) ? '0 : cells[rb];

  // R10
  zero_reg_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ra == '0) |-> (rd_a == '0));
  // R10
  zero_reg_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rb == '0) |-> (rd_b == '0));
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] opcode,
  output ctl_t       ctl
);
  step_e step_q, step_d;

  always_comb begin
    step_d = ST_FETCH;
    case (step_q)
      ST_FETCH:  step_d = ST_DECODE;
      ST_DECODE: begin
        case (opcode)
          OP_LOAD, OP_STOR: step_d = ST_ADDR;
          OP_REG:           step_d = ST_REXE;
          OP_BEQ:           step_d = ST_BR;
          OP_JMP:           step_d = ST_JMP;
          default:          step_d = ST_FETCH;
        endcase
      end
      ST_ADDR:  step_d = (opcode == OP_LOAD) ? ST_LDRD : ST_STWR;
      ST_LDRD:  step_d = ST_LDWB;
      ST_REXE:  step_d = ST_RWB;
      default:  step_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= ST_FETCH;
    else        step_q <= step_d;
  end

  always_comb begin
    ctl = '0;
    case (step_q)
      ST_FETCH: begin
        ctl.mem_re = 1'b1;
        ctl.ir_we  = 1'b1;
        ctl.srcb   = SB_FOUR;
        ctl.aluop  = AM_ADD;
        ctl.pcsrc  = PS_ALU;
        ctl.pc_we  = 1'b1;
      end
      ST_DECODE: begin
        ctl.ab_we  = 1'b1;
        ctl.srcb   = SB_IMMX4;
        ctl.aluop  = AM_ADD;
        ctl.out_we = 1'b1;
        ctl.retire = !op_known(opcode);
      end
      ST_ADDR: begin
        ctl.srca_reg = 1'b1;
        ctl.srcb     = SB_IMM;
        ctl.aluop    = AM_ADD;
        ctl.out_we   = 1'b1;
      end
      ST_LDRD: begin
        ctl.mem_re    = 1'b1;
        ctl.data_addr = 1'b1;
      end
      ST_LDWB: begin
        ctl.rf_we  = 1'b1;
        ctl.wb_mem = 1'b1;
        ctl.retire = 1'b1;
      end
      ST_STWR: begin
        ctl.mem_we    = 1'b1;
        ctl.data_addr = 1'b1;
        ctl.retire    = 1'b1;
      end
      ST_REXE: begin
        ctl.srca_reg = 1'b1;
        ctl.srcb     = SB_REG;
        ctl.aluop    = AM_FUNCT;
        ctl.out_we   = 1'b1;
      end
      ST_RWB: begin
        ctl.rf_we  = 1'b1;
        ctl.dst_rd = 1'b1;
        ctl.retire = 1'b1;
      end
      ST_BR: begin
        ctl.srca_reg   = 1'b1;
        ctl.srcb       = SB_REG;
        ctl.aluop      = AM_SUB;
        ctl.pc_we_cond = 1'b1;
        ctl.pcsrc      = PS_HELD;
        ctl.retire     = 1'b1;
      end
      ST_JMP: begin
        ctl.pc_we  = 1'b1;
        ctl.pcsrc  = PS_JUMP;
        ctl.retire = 1'b1;
      end
      default: ctl = '0;
    endcase
  end

  // R9
  unknown_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_DECODE && !op_known(opcode)) |=> (step_q == ST_FETCH));
  // R4
  load_wb_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_LDRD) |=> (step_q == ST_LDWB));
  // R11
  retire_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.retire |=> !ctl.retire);
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  output logic [XLEN-1:0]   mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic              retire,
  output logic              rf_wr_en,
  output logic [RIDX_W-1:0] rf_wr_idx,
  output logic [XLEN-1:0]   rf_wr_data
);
  localparam int IMM_W = 16;

  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  ctl_t ctl;
  logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, out_q;
  logic [XLEN-1:0] pc_d, rf_a, rf_b, alu_a, alu_b, alu_res, imm_ext, jmp_tgt;
  logic            alu_zero, pc_en;

  logic [5:0]        f_op, f_fn;
  logic [RIDX_W-1:0] f_rs, f_rt, f_rd;
  assign f_op = ir_q[31:26];
  assign f_rs = ir_q[25:21];
  assign f_rt = ir_q[20:16];
  assign f_rd = ir_q[15:11];
  assign f_fn = ir_q[5:0];
  assign imm_ext = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
  assign jmp_tgt = {pc_q[XLEN-1:XLEN-4], ir_q[25:0], 2'b00};

  mc_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .opcode (f_op),
    .ctl    (ctl)
  );

  mc_regfile #(.W(XLEN), .N(NREGS)) u_rf (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (ctl.rf_we),
    .wa    (rf_wr_idx),
    .wd    (rf_wr_data),
    .ra    (f_rs),
    .rb    (f_rt),
    .rd_a  (rf_a),
    .rd_b  (rf_b)
  );

  always_comb begin
    alu_a = ctl.srca_reg ? a_q : pc_q;
    case (ctl.srcb)
      SB_REG:   alu_b = b_q;
      SB_FOUR:  alu_b = XLEN'(4);
      SB_IMM:   alu_b = imm_ext;
      default:  alu_b = imm_ext << 2;
    endcase
  end

  mc_alu #(.W(XLEN)) u_alu (
    .op_a   (alu_a),
    .op_b   (alu_b),
    .mode   (ctl.aluop),
    .funct  (f_fn),
    .result (alu_res),
    .zero   (alu_zero)
  );

  always_comb begin
    case (ctl.pcsrc)
      PS_HELD: pc_d = out_q;
      PS_JUMP: pc_d = jmp_tgt;
      default: pc_d = alu_res;
    endcase
  end
  assign pc_en = ctl.pc_we | (ctl.pc_we_cond & alu_zero);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pc_q  <= '0;
      ir_q  <= '0;
      mdr_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
      out_q <= '0;
    end else begin
      if (pc_en)                         pc_q  <= pc_d;
      if (ctl.ir_we)                     ir_q  <= mem_rdata;
      if (ctl.mem_re && ctl.data_addr)   mdr_q <= mem_rdata;
      if (ctl.ab_we)                     a_q   <= rf_a;
      if (ctl.ab_we)                     b_q   <= rf_b;
      if (ctl.out_we)                    out_q <= alu_res;
    end
  end

  assign mem_addr   = ctl.data_addr ? out_q : pc_q;
  assign mem_re     = ctl.mem_re;
  assign mem_we     = ctl.mem_we;
  assign mem_wdata  = b_q;
  assign retire     = ctl.retire;
  assign rf_wr_en   = ctl.rf_we;
  assign rf_wr_idx  = ctl.dst_rd ? f_rd : f_rt;
  assign rf_wr_data = ctl.wb_mem ? mdr_q : out_q;

  // R11
  single_mem_access_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(mem_re && mem_we));
  // R2
  fetch_advance_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ctl.ir_we |=> (pc_q == $past(pc_q) + XLEN'(4)));
  // R6
  branch_untaken_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ctl.pc_we_cond && !alu_zero) |=> (pc_q == $past(pc_q)));
endmodule

// File: tb/mc_core_bench.sv
module mc_core_bench;
  import mc_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int MWORDS     = 128;
  localparam int RUN_RETIRES = 40;
  localparam int WATCHDOG    = 5000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_wr_data;
  logic        mem_re, mem_we, retire, rf_wr_en;
  logic [4:0]  rf_wr_idx;

  logic [31:0] bench_mem [MWORDS];
  logic [31:0] model_mem [MWORDS];
  logic [31:0] model_rf  [32];
  logic [31:0] model_pc;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_core u_mc_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_addr   (mem_addr),
    .mem_re     (mem_re),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .retire     (retire),
    .rf_wr_en   (rf_wr_en),
    .rf_wr_idx  (rf_wr_idx),
    .rf_wr_data (rf_wr_data)
  );

  assign mem_rdata = bench_mem[mem_addr[8:2]];
  always @(posedge clk) begin
    if (mem_we) bench_mem[mem_addr[8:2]] <= mem_wdata;
  end

  function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                        input logic [4:0] rd, input logic [5:0] fn);
    return {OP_REG, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // per-instruction expectations from the instruction-level model
  int          cyc;
  int          exp_cyc;
  logic        exp_wb, exp_st, seen_wb, seen_st;
  logic [4:0]  exp_wb_idx;
  logic [31:0] exp_wb_data, exp_st_addr, exp_st_data, next_pc;
  string       tag, cyc_tag;

  task automatic predict();
    logic [31:0] ins, ra, rb, sx, pc4;
    logic [5:0]  op, fn;
    logic [4:0]  rs, rt, rd;
    ins = model_mem[model_pc[8:2]];
    op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11]; fn = ins[5:0];
    ra = model_rf[rs]; rb = model_rf[rt];
    sx = {{16{ins[15]}}, ins[15:0]};
    pc4 = model_pc + 32'd4;
    exp_wb = 1'b0; exp_st = 1'b0; seen_wb = 1'b0; seen_st = 1'b0;
    exp_wb_idx = '0; exp_wb_data = '0; exp_st_addr = '0; exp_st_data = '0;
    next_pc = pc4;
    case (op)
      OP_REG: begin
        exp_cyc = 4; tag = "R3"; cyc_tag = "R8";
        exp_wb = 1'b1; exp_wb_idx = rd;
        case (fn)
          FN_SUB:  exp_wb_data = ra - rb;
          FN_AND:  exp_wb_data = ra & rb;
          FN_OR:   exp_wb_data = ra | rb;
          FN_SLT:  exp_wb_data = ($signed(ra) < $signed(rb)) ? 32'd1 : 32'd0;
          default: exp_wb_data = ra + rb;
        endcase
      end
      OP_LOAD: begin
        exp_cyc = 5; tag = "R4"; cyc_tag = "R4";
        exp_wb = 1'b1; exp_wb_idx = rt;
        exp_wb_data = model_mem[(ra + sx) >> 2];
      end
      OP_STOR: begin
        exp_cyc = 4; tag = (rt == 5'd0) ? "R10" : "R5"; cyc_tag = "R5";
        exp_st = 1'b1; exp_st_addr = ra + sx; exp_st_data = rb;
      end
      OP_BEQ: begin
        exp_cyc = 3; tag = "R6"; cyc_tag = "R6";
        if (ra == rb) next_pc = pc4 + (sx << 2);
      end
      OP_JMP: begin
        exp_cyc = 3; tag = "R7"; cyc_tag = "R7";
        next_pc = {pc4[31:28], ins[25:0], 2'b00};
      end
      default: begin
        exp_cyc = 2; tag = "R9"; cyc_tag = "R9";
      end
    endcase
  endtask

  int retired = 0;
  int cycles  = 0;

  initial begin
    for (int i = 0; i < MWORDS; i++) bench_mem[i] = '0;
    for (int i = 0; i < 32; i++) model_rf[i] = '0;
    bench_mem[0]  = enc_i(OP_LOAD, 0, 1, 16'h0100);
    bench_mem[1]  = enc_i(OP_LOAD, 0, 2, 16'h0104);
    bench_mem[2]  = enc_r(1, 2, 3, FN_ADD);
    bench_mem[3]  = enc_r(1, 2, 4, FN_SUB);
    bench_mem[4]  = enc_r(1, 2, 5, FN_AND);
    bench_mem[5]  = enc_r(1, 2, 6, FN_OR);
    bench_mem[6]  = enc_r(2, 1, 7, FN_SLT);
    bench_mem[7]  = enc_r(1, 2, 8, FN_SLT);
    bench_mem[8]  = enc_i(OP_STOR, 0, 3, 16'h0108);
    bench_mem[9]  = enc_r(1, 1, 0, FN_ADD);
    bench_mem[10] = enc_i(OP_STOR, 0, 0, 16'h010C);
    bench_mem[11] = enc_i(OP_BEQ, 1, 2, 16'd5);
    bench_mem[12] = {6'h3F, 26'h0};
    bench_mem[13] = enc_i(OP_BEQ, 1, 1, 16'd2);
    bench_mem[14] = enc_r(1, 1, 9, FN_ADD);
    bench_mem[15] = enc_r(1, 1, 9, FN_ADD);
    bench_mem[16] = enc_i(OP_LOAD, 0, 11, 16'h0110);
    bench_mem[17] = enc_i(OP_LOAD, 0, 12, 16'h0114);
    bench_mem[18] = enc_r(11, 12, 11, FN_SUB);
    bench_mem[19] = enc_i(OP_BEQ, 11, 0, 16'd1);
    bench_mem[20] = enc_i(OP_BEQ, 0, 0, 16'hFFFD);
    bench_mem[21] = enc_i(OP_STOR, 0, 11, 16'h0118);
    bench_mem[22] = {OP_JMP, 26'd22};
    bench_mem[64] = 32'd5;
    bench_mem[65] = 32'hFFFF_FFFD;
    bench_mem[68] = 32'd3;
    bench_mem[69] = 32'd1;
    for (int i = 0; i < MWORDS; i++) model_mem[i] = bench_mem[i];
    model_pc = '0;

    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1", "reset address", mem_addr, 32'h0);
    check("R1", "reset mem write", {31'd0, mem_we}, 32'd0);
    check("R1", "reset reg write", {31'd0, rf_wr_en}, 32'd0);
    check("R1", "reset retire", {31'd0, retire}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    cyc = 0;
    while (retired < RUN_RETIRES && cycles < WATCHDOG) begin
      @(negedge clk);
      cycles++;
      if (cyc == 0) begin
        predict();
        // R2: fetch from the model PC (targets from R6/R7 land here)
        check("R2", "fetch address", mem_addr, model_pc);
        check("R2", "fetch read request", {31'd0, mem_re}, 32'd1);
      end
      // R11: never read and write together
      check("R11", "read with write", {31'd0, mem_re & mem_we}, 32'd0);
      if (rf_wr_en) begin
        seen_wb = 1'b1;
        check(tag, "write allowed this cycle", {31'd0, exp_wb && (cyc == exp_cyc - 1)}, 32'd1);
        check(tag, "write index", {27'd0, rf_wr_idx}, {27'd0, exp_wb_idx});
        check(tag, "write data", rf_wr_data, exp_wb_data);
      end
      if (mem_we) begin
        seen_st = 1'b1;
        check(tag, "store allowed this cycle", {31'd0, exp_st && (cyc == exp_cyc - 1)}, 32'd1);
        check(tag, "store address", mem_addr, exp_st_addr);
        check(tag, "store data", mem_wdata, exp_st_data);
      end
      if (retire) begin
        check(cyc_tag, "cycle count", cyc + 1, exp_cyc);
        check(tag, "register write seen", {31'd0, seen_wb}, {31'd0, exp_wb});
        check(tag, "store seen", {31'd0, seen_st}, {31'd0, exp_st});
        if (exp_wb && exp_wb_idx != 5'd0) model_rf[exp_wb_idx] = exp_wb_data;
        if (exp_st) model_mem[exp_st_addr[8:2]] = exp_st_data;
        model_pc = next_pc;
        retired++;
        cyc = 0;
      end else begin
        cyc++;
        if (cyc >= exp_cyc) begin
          check(cyc_tag, "retire missing by cycle", cyc, exp_cyc - 1);
          cyc = 0;
          model_pc = next_pc;
        end
      end
    end
    if (cycles >= WATCHDOG) check("R11", "watchdog expired", 32'd1, 32'd0);
    // R5/R10 stored values visible at memory
    check("R5", "stored sum", bench_mem[66], 32'd2);
    check("R10", "stored register zero", bench_mem[67], 32'd0);
    check("R6", "loop result stored", bench_mem[70], 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule